// File: doc/BRIEF.md
# I2C Controller Command and Status Registers

This block is the software-facing command and status logic of a two-wire serial controller. A simple register port (select, write strobe, write data, read data) lets software read and write a control register, a status register and a data register. The block turns control-register writes into START and STOP requests toward a bit-level bus engine that sits outside it. That engine answers each request with a one-cycle done strobe, reports START and STOP conditions it sees on the bus, says whether the controller currently acts as master, and loads a 5-bit state code whenever a bus step completes.

The block tracks whether another master holds the bus. It holds back a START until the bus is free, and it orders a combined STOP-then-START request. In slave mode, a STOP request becomes a return to the unaddressed slave state with the lines released. The block clears request bits when the engine reports them done, and aborts everything when the controller is disabled. It raises an interrupt while the step-complete flag is set and both local and global interrupt enables are on. It also refuses data-register writes made while a step is still in progress, and flags each such attempt as a collision.

Top module: `i2c_csr_regs`

## Requirements
- R1: After synchronous reset the control register reads 0x00, the status register reads 0xF8 (code 5'h1F, prescaler 0), the data register reads 0x00, and `irq`, `start_req`, `stop_req`, `bus_busy` and `pins_owned` are all low.
- R2: Control register (select 0) layout: bit 0 enable, bit 1 interrupt enable, bit 2 start request, bit 3 stop request, bit 4 write-collision flag, bit 7 step-complete flag. Writing 1 to bit 2 with bit 0 set, while the bus is idle and no stop is pending, raises `start_req` in the cycle after the write.
- R3: A start request made while `bus_busy` is high keeps `start_req` low. `start_req` rises in the cycle after `bus_stop_det` clears the busy flag.
- R4: `start_done` clears the start request bit and drops `start_req` in the next cycle.
- R5: In master mode (`master_mode` high), writing 1 to bit 3 with bit 0 set raises `stop_req` in the next cycle. `stop_done` clears the bit and drops `stop_req`.
- R6: In slave mode, writing 1 to bit 3 with bit 0 set never raises `stop_req`. Instead it gives a one-cycle `slave_release` pulse in the next cycle, and bit 3 reads 0.
- R7: With both start and stop requested, `start_req` stays low until the stop is done and the bus is free.
- R8: A write to the data register (select 2) while the step-complete flag is low leaves the data unchanged and sets bit 4. A write while the flag is high stores the byte (visible on `tx_byte`) and clears bit 4.
- R9: A control write with bit 0 clear drops `start_req`, `stop_req` and `pins_owned` and clears both request bits. If the block was enabled, `xfer_abort` pulses for one cycle. A start request written while disabled is not taken.
- R10: `irq` is high exactly when the step-complete flag, the interrupt enable bit and `global_irq_en` are all high.
- R11: Status register (select 1) reads {code[4:0], 1'b0, prescaler[1:0]}. Writes change only the prescaler, which also drives `prescale_sel`. `status_load` loads `status_code` and sets the step-complete flag. Writing 1 to control bit 7 clears that flag, but a load in the same cycle wins.
- R12: Control bits 6:5 always read 0. Writes to bits 6:4 are ignored. Writing 0 to bit 2 or bit 3 has no effect.
- R13: `bus_start_det` sets `bus_busy` in the next cycle, and `bus_stop_det` alone clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 2 | Register select: 0 control, 1 status, 2 data, 3 unmapped (reads 0) |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Read data of the selected register (combinational) |
| global_irq_en | input | 1 | System-wide interrupt enable |
| master_mode | input | 1 | From bus engine: controller is currently master |
| bus_start_det | input | 1 | From bus engine: START condition seen on the bus |
| bus_stop_det | input | 1 | From bus engine: STOP condition seen on the bus |
| start_done | input | 1 | From bus engine: requested START has been sent |
| stop_done | input | 1 | From bus engine: requested STOP has been executed |
| status_load | input | 1 | From bus engine: load state code, set step-complete flag |
| status_code | input | 5 | State code loaded by `status_load` |
| start_req | output | 1 | Request to send a START |
| stop_req | output | 1 | Request to send a STOP |
| slave_release | output | 1 | One-cycle pulse: go to unaddressed slave, release both lines |
| xfer_abort | output | 1 | One-cycle pulse: controller disabled, abort any transfer |
| pins_owned | output | 1 | Controller drives the clock and data pins |
| bus_busy | output | 1 | Another START seen and no STOP since |
| tx_byte | output | 8 | Data register contents toward the engine |
| prescale_sel | output | 2 | Bit-rate prescaler select |
| irq | output | 1 | Interrupt request |

## Verification
The hardest case to reach is a START held back behind a busy bus while a STOP is also pending. The bus must first be marked busy through `bus_start_det`, a combined start and stop request is then written, and the bench releases `stop_done` and `bus_stop_det` in separate cycles. This shows that `start_req` waits for both events and does not rise after the first. The same busy-bus setup lets the bench write a disable in the middle of the wait and then free the bus, which shows that the cancelled start never fires. A sweep of every state code against every prescaler value, and of all eight flag and enable combinations for the interrupt, covers the packing and the gating arithmetically.

// File: rtl/i2c_csr_pkg.sv
package i2c_csr_pkg;

    localparam int DW     = 8;
    localparam int CODE_W = 5;
    localparam int PSC_W  = 2;
    localparam int AW     = 2;
    localparam int RSV_W  = DW - CODE_W - PSC_W;

    // control register bit positions
    localparam int B_EN   = 0;
    localparam int B_IE   = 1;
    localparam int B_STA  = 2;
    localparam int B_STO  = 3;
    localparam int B_FLAG = 7;

    localparam logic [CODE_W-1:0] CODE_RESET = '1;

    typedef enum logic [AW-1:0] {
        SEL_CTRL = 2'd0,
        SEL_STAT = 2'd1,
        SEL_DATA = 2'd2,
        SEL_NONE = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic [CODE_W-1:0] code;
        logic [RSV_W-1:0]  rsv;
        logic [PSC_W-1:0]  psc;
    } stat_view_t;

    typedef struct packed {
        logic       flag;
        logic [1:0] rsv;
        logic       coll;
        logic       sto;
        logic       sta;
        logic       ie;
        logic       en;
    } ctrl_view_t;

    function automatic logic [DW-1:0] pack_stat(input logic [CODE_W-1:0] c,
                                                input logic [PSC_W-1:0]  p);
        stat_view_t s;
        s.code = c;
        s.rsv  = '0;
        s.psc  = p;
        return s;
    endfunction

endpackage

// File: rtl/i2c_busy_track.sv
module i2c_busy_track (
    input  logic clk,
    input  logic rst,
    input  logic start_seen,
    input  logic stop_seen,
    output logic busy
);
    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
        end else if (start_seen) begin
            busy <= 1'b1;
        end else if (stop_seen) begin
            busy <= 1'b0;
        end
    end
endmodule

// File: rtl/i2c_req_seq.sv
module i2c_req_seq (
    input  logic clk,
    input  logic rst,
    input  logic ctrl_wr,
    input  logic wr_en,
    input  logic wr_sta,
    input  logic wr_sto,
    input  logic master_mode,
    input  logic busy,
    input  logic start_done,
    input  logic stop_done,
    output logic en_q,
    output logic sta_q,
    output logic sto_q,
    output logic start_req,
    output logic stop_req,
    output logic slave_rel,
    output logic abort
);
    logic go_q;

    // START held once issued; fresh issue only on an idle bus with no STOP pending
    always_comb begin
        start_req = en_q & (go_q | (sta_q & ~busy & ~sto_q));
        stop_req  = en_q & sto_q & master_mode;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q      <= 1'b0;
            sta_q     <= 1'b0;
            sto_q     <= 1'b0;
            go_q      <= 1'b0;
            slave_rel <= 1'b0;
            abort     <= 1'b0;
        end else begin
            slave_rel <= 1'b0;
            abort     <= 1'b0;
            go_q      <= start_req & ~start_done;
            if (start_done) sta_q <= 1'b0;
            if (stop_done)  sto_q <= 1'b0;
            if (ctrl_wr) begin
                en_q <= wr_en;
                if (!wr_en) begin
                    sta_q <= 1'b0;
                    sto_q <= 1'b0;
                    go_q  <= 1'b0;
                    abort <= en_q;
                end else begin
                    if (wr_sta) sta_q <= 1'b1;
                    if (wr_sto) begin
                        if (master_mode) begin
                            sto_q <= 1'b1;
                        end else begin
                            sto_q     <= 1'b0;
                            slave_rel <= 1'b1;
                        end
                    end
                end
            end
        end
    end
endmodule

// File: rtl/i2c_flag_unit.sv
module i2c_flag_unit
    import i2c_csr_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          ctrl_wr,
    input  logic          wr_ie,
    input  logic          wr_flag_clr,
    input  logic          data_wr,
    input  logic [DW-1:0] wdata,
    input  logic          status_load,
    input  logic          global_irq_en,
    output logic          flag_q,
    output logic          ie_q,
    output logic          coll_q,
    output logic [DW-1:0] data_q,
    output logic          irq
);
    always_ff @(posedge clk) begin
        if (rst) begin
            flag_q <= 1'b0;
            ie_q   <= 1'b0;
            coll_q <= 1'b0;
            data_q <= '0;
        end else begin
            if (ctrl_wr) ie_q <= wr_ie;
            // hardware set wins over the software clear
            if (status_load) begin
                flag_q <= 1'b1;
            end else if (ctrl_wr && wr_flag_clr) begin
                flag_q <= 1'b0;
            end
            if (data_wr) begin
                if (flag_q) begin
                    data_q <= wdata;
                    coll_q <= 1'b0;
                end else begin
                    coll_q <= 1'b1;
                end
            end
        end
    end

    assign irq = flag_q & ie_q & global_irq_en;
endmodule

// File: rtl/i2c_status_reg.sv
module i2c_status_reg
    import i2c_csr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              stat_wr,
    input  logic [PSC_W-1:0]  wr_psc,
    input  logic              load,
    input  logic [CODE_W-1:0] load_code,
    output logic [CODE_W-1:0] code_q,
    output logic [PSC_W-1:0]  psc_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            code_q <= CODE_RESET;
            psc_q  <= '0;
        end else begin
            if (load)    code_q <= load_code;
            if (stat_wr) psc_q  <= wr_psc;
        end
    end
endmodule

// File: rtl/i2c_csr_regs.sv
module i2c_csr_regs
    import i2c_csr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [AW-1:0]     reg_addr,
    input  logic              reg_wr,
    input  logic [DW-1:0]     reg_wdata,
    output logic [DW-1:0]     reg_rdata,
    input  logic              global_irq_en,
    input  logic              master_mode,
    input  logic              bus_start_det,
    input  logic              bus_stop_det,
    input  logic              start_done,
    input  logic              stop_done,
    input  logic              status_load,
    input  logic [CODE_W-1:0] status_code,
    output logic              start_req,
    output logic              stop_req,
    output logic              slave_release,
    output logic              xfer_abort,
    output logic              pins_owned,
    output logic              bus_busy,
    output logic [DW-1:0]     tx_byte,
    output logic [PSC_W-1:0]  prescale_sel,
    output logic              irq
);
    reg_sel_e sel;
    logic ctrl_wr, stat_wr, data_wr;
    logic en_q, sta_q, sto_q;
    logic flag_q, ie_q, coll_q;
    logic [CODE_W-1:0] code_q;
    logic [PSC_W-1:0]  psc_q;
    ctrl_view_t ctrl_rd;

    always_comb begin
        sel     = reg_sel_e'(reg_addr);
        ctrl_wr = reg_wr && (sel == SEL_CTRL);
        stat_wr = reg_wr && (sel == SEL_STAT);
        data_wr = reg_wr && (sel == SEL_DATA);
    end

    i2c_busy_track u_busy (
        .clk        (clk),
        .rst        (rst),
        .start_seen (bus_start_det),
        .stop_seen  (bus_stop_det),
        .busy       (bus_busy)
    );

    i2c_req_seq u_seq (
        .clk         (clk),
        .rst         (rst),
        .ctrl_wr     (ctrl_wr),
        .wr_en       (reg_wdata[B_EN]),
        .wr_sta      (reg_wdata[B_STA]),
        .wr_sto      (reg_wdata[B_STO]),
        .master_mode (master_mode),
        .busy        (bus_busy),
        .start_done  (start_done),
        .stop_done   (stop_done),
        .en_q        (en_q),
        .sta_q       (sta_q),
        .sto_q       (sto_q),
        .start_req   (start_req),
        .stop_req    (stop_req),
        .slave_rel   (slave_release),
        .abort       (xfer_abort)
    );

    i2c_flag_unit u_flag (
        .clk           (clk),
        .rst           (rst),
        .ctrl_wr       (ctrl_wr),
        .wr_ie         (reg_wdata[B_IE]),
        .wr_flag_clr   (reg_wdata[B_FLAG]),
        .data_wr       (data_wr),
        .wdata         (reg_wdata),
        .status_load   (status_load),
        .global_irq_en (global_irq_en),
        .flag_q        (flag_q),
        .ie_q          (ie_q),
        .coll_q        (coll_q),
        .data_q        (tx_byte),
        .irq           (irq)
    );

    i2c_status_reg u_stat (
        .clk       (clk),
        .rst       (rst),
        .stat_wr   (stat_wr),
        .wr_psc    (reg_wdata[PSC_W-1:0]),
        .load      (status_load),
        .load_code (status_code),
        .code_q    (code_q),
        .psc_q     (psc_q)
    );

    assign pins_owned   = en_q;
    assign prescale_sel = psc_q;

    always_comb begin
        ctrl_rd      = '0;
        ctrl_rd.flag = flag_q;
        ctrl_rd.coll = coll_q;
        ctrl_rd.sto  = sto_q;
        ctrl_rd.sta  = sta_q;
        ctrl_rd.ie   = ie_q;
        ctrl_rd.en   = en_q;
        case (sel)
            SEL_CTRL: reg_rdata = ctrl_rd;
            SEL_STAT: reg_rdata = pack_stat(code_q, psc_q);
            SEL_DATA: reg_rdata = tx_byte;
            default:  reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/i2c_csr_chk.sv
module i2c_csr_chk
    import i2c_csr_pkg::*;
(
    input logic          clk,
    input logic          rst,
    input logic          ctrl_wr,
    input logic [DW-1:0] reg_wdata,
    input logic          master_mode,
    input logic          bus_start_det,
    input logic          bus_stop_det,
    input logic          start_done,
    input logic          stop_done,
    input logic          status_load,
    input logic          global_irq_en,
    input logic          flag_q,
    input logic          start_req,
    input logic          stop_req,
    input logic          slave_release,
    input logic          xfer_abort,
    input logic          pins_owned,
    input logic          bus_busy,
    input logic          irq
);
    a_r3_start_on_idle_bus: assert property (@(posedge clk) disable iff (rst)
        $rose(start_req) |-> !bus_busy);

    a_r4_start_done_drops: assert property (@(posedge clk) disable iff (rst)
        (start_done && !ctrl_wr) |=> !start_req);

    a_r5_stop_done_drops: assert property (@(posedge clk) disable iff (rst)
        (stop_done && !ctrl_wr) |=> !stop_req);

    a_r6_slave_stop_releases: assert property (@(posedge clk) disable iff (rst)
        (ctrl_wr && reg_wdata[B_EN] && reg_wdata[B_STO] && !master_mode)
        |=> (slave_release && !stop_req));

    a_r7_stop_before_start: assert property (@(posedge clk) disable iff (rst)
        $rose(start_req) |-> !stop_req);

    a_r9_disable_clears: assert property (@(posedge clk) disable iff (rst)
        (ctrl_wr && !reg_wdata[B_EN]) |=> (!start_req && !stop_req && !pins_owned));

    a_r9_abort_pulse: assert property (@(posedge clk) disable iff (rst)
        (ctrl_wr && !reg_wdata[B_EN] && pins_owned) |=> xfer_abort);

    a_r10_irq_needs_global: assert property (@(posedge clk) disable iff (rst)
        irq |-> global_irq_en);

    a_r11_load_sets_flag: assert property (@(posedge clk) disable iff (rst)
        status_load |=> flag_q);

    a_r13_start_sets_busy: assert property (@(posedge clk) disable iff (rst)
        bus_start_det |=> bus_busy);

    a_r13_stop_clears_busy: assert property (@(posedge clk) disable iff (rst)
        (bus_stop_det && !bus_start_det) |=> !bus_busy);
endmodule

bind i2c_csr_regs i2c_csr_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .ctrl_wr       (ctrl_wr),
    .reg_wdata     (reg_wdata),
    .master_mode   (master_mode),
    .bus_start_det (bus_start_det),
    .bus_stop_det  (bus_stop_det),
    .start_done    (start_done),
    .stop_done     (stop_done),
    .status_load   (status_load),
    .global_irq_en (global_irq_en),
    .flag_q        (flag_q),
    .start_req     (start_req),
    .stop_req      (stop_req),
    .slave_release (slave_release),
    .xfer_abort    (xfer_abort),
    .pins_owned    (pins_owned),
    .bus_busy      (bus_busy),
    .irq           (irq)
);

// File: tb/i2c_csr_regs_test.sv
`timescale 1ns/10ps
module i2c_csr_regs_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] reg_addr = 2'd0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = 8'd0;
    logic [7:0] reg_rdata;
    logic       global_irq_en = 1'b0;
    logic       master_mode = 1'b1;
    logic       bus_start_det = 1'b0;
    logic       bus_stop_det = 1'b0;
    logic       start_done = 1'b0;
    logic       stop_done = 1'b0;
    logic       status_load = 1'b0;
    logic [4:0] status_code = 5'd0;
    logic       start_req, stop_req, slave_release, xfer_abort;
    logic       pins_owned, bus_busy, irq;
    logic [7:0] tx_byte;
    logic [1:0] prescale_sel;

    int nvec = 0;
    int nbad = 0;
    bit finished = 1'b0;

    localparam logic [7:0] C_EN = 8'h01, C_IE = 8'h02, C_STA = 8'h04,
                           C_STO = 8'h08, C_FLAG = 8'h80;

    always #2.5 clk = ~clk;

    i2c_csr_regs uut (
        .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .global_irq_en(global_irq_en), .master_mode(master_mode),
        .bus_start_det(bus_start_det), .bus_stop_det(bus_stop_det),
        .start_done(start_done), .stop_done(stop_done),
        .status_load(status_load), .status_code(status_code),
        .start_req(start_req), .stop_req(stop_req),
        .slave_release(slave_release), .xfer_abort(xfer_abort),
        .pins_owned(pins_owned), .bus_busy(bus_busy), .tx_byte(tx_byte),
        .prescale_sel(prescale_sel), .irq(irq)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input int act, input int exp);
        nvec++;
        if (act !== exp) begin
            nbad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        tick();
        reg_wr = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [1:0] a, input int exp);
        reg_addr = a;
        #0.2;
        chk(req, int'(reg_rdata), exp);
    endtask

    task automatic pulse_start_det(); bus_start_det = 1; tick(); bus_start_det = 0; endtask
    task automatic pulse_stop_det();  bus_stop_det  = 1; tick(); bus_stop_det  = 0; endtask
    task automatic load_code(input logic [4:0] c);
        status_code = c; status_load = 1; tick(); status_load = 0;
    endtask

    initial begin
        #(5.0 * 100000);
        if (!finished) begin
            nbad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
            $finish;
        end
    end

    initial begin
        repeat (3) tick();
        rst = 1'b0;
        tick();
        // R1 reset state
        rd_chk("R1 ctrl", 2'd0, 8'h00);
        rd_chk("R1 status", 2'd1, 8'hF8);
        rd_chk("R1 data", 2'd2, 8'h00);
        chk("R1 irq", irq, 0);
        chk("R1 start_req", start_req, 0);
        chk("R1 stop_req", stop_req, 0);
        chk("R1 busy", bus_busy, 0);
        chk("R1 pins", pins_owned, 0);

        // R13 busy tracking
        pulse_start_det();
        chk("R13 busy set", bus_busy, 1);
        pulse_stop_det();
        chk("R13 busy clear", bus_busy, 0);

        // R2 start on idle bus
        master_mode = 1;
        wr(2'd0, C_EN | C_STA);
        chk("R2 start_req", start_req, 1);
        chk("R2 pins", pins_owned, 1);
        rd_chk("R2 ctrl", 2'd0, 8'h05);
        // R4 done clears
        bus_start_det = 1; start_done = 1; tick(); bus_start_det = 0; start_done = 0;
        chk("R4 start_req drop", start_req, 0);
        rd_chk("R4 ctrl", 2'd0, 8'h01);

        // R5 master stop
        wr(2'd0, C_EN | C_STO);
        chk("R5 stop_req", stop_req, 1);
        stop_done = 1; bus_stop_det = 1; tick(); stop_done = 0; bus_stop_det = 0;
        chk("R5 stop_req drop", stop_req, 0);
        rd_chk("R5 ctrl", 2'd0, 8'h01);
        chk("R13 busy after stop", bus_busy, 0);

        // R3 start waits on busy bus
        pulse_start_det();
        wr(2'd0, C_EN | C_STA);
        chk("R3 held", start_req, 0);
        repeat (3) tick();
        chk("R3 still held", start_req, 0);
        pulse_stop_det();
        chk("R3 fires after stop", start_req, 1);
        start_done = 1; tick(); start_done = 0;
        chk("R4 drop again", start_req, 0);

        // R7 stop first, then start
        pulse_start_det();
        wr(2'd0, C_EN | C_STA | C_STO);
        chk("R7 stop_req", stop_req, 1);
        chk("R7 start held", start_req, 0);
        stop_done = 1; tick(); stop_done = 0;
        chk("R7 stop done", stop_req, 0);
        chk("R7 start waits bus", start_req, 0);
        pulse_stop_det();
        chk("R7 start fires", start_req, 1);
        start_done = 1; tick(); start_done = 0;

        // R6 slave stop
        master_mode = 0;
        wr(2'd0, C_EN | C_STO);
        chk("R6 release pulse", slave_release, 1);
        chk("R6 no stop_req", stop_req, 0);
        rd_chk("R6 ctrl bit3", 2'd0, 8'h01);
        tick();
        chk("R6 pulse ends", slave_release, 0);
        master_mode = 1;

        // R12 writing 0 to request bits has no effect
        pulse_start_det();
        wr(2'd0, C_EN | C_STA);
        wr(2'd0, C_EN);
        rd_chk("R12 sta kept", 2'd0, 8'h05);

        // R9 disable aborts
        wr(2'd0, 8'h00);
        chk("R9 abort", xfer_abort, 1);
        chk("R9 pins", pins_owned, 0);
        chk("R9 start_req", start_req, 0);
        rd_chk("R9 ctrl", 2'd0, 8'h00);
        tick();
        chk("R9 abort ends", xfer_abort, 0);
        pulse_stop_det();
        chk("R9 cancelled start", start_req, 0);
        wr(2'd0, C_STA);
        chk("R9 start while off", start_req, 0);
        rd_chk("R9 ctrl off", 2'd0, 8'h00);

        // R8 collision guard
        wr(2'd2, 8'hA5);
        rd_chk("R8 coll set", 2'd0, 8'h10);
        rd_chk("R8 data kept", 2'd2, 8'h00);
        // R12 reserved bits and collision bit ignore writes
        wr(2'd0, 8'h60);
        rd_chk("R12 reserved", 2'd0, 8'h10);
        load_code(5'd3);
        rd_chk("R11 flag set", 2'd0, 8'h90);
        wr(2'd2, 8'h3C);
        rd_chk("R8 coll clear", 2'd0, 8'h80);
        rd_chk("R8 data stored", 2'd2, 8'h3C);
        chk("R8 tx_byte", tx_byte, 8'h3C);
        // R11 set beats clear in same cycle
        status_code = 5'd9; status_load = 1;
        wr(2'd0, C_FLAG);
        status_load = 0;
        rd_chk("R11 set wins", 2'd0, 8'h80);
        wr(2'd0, C_FLAG);
        rd_chk("R11 flag clear", 2'd0, 8'h00);

        // R11 sweep of code and prescaler
        for (int c = 0; c < 32; c++) begin
            for (int p = 0; p < 4; p++) begin
                load_code(5'(c));
                wr(2'd1, {~5'(c), 1'b1, 2'(p)});
                rd_chk("R11 status", 2'd1, (c << 3) | p);
                chk("R11 prescale", prescale_sel, p);
                rd_chk("R11 flag", 2'd0, 8'h80);
                wr(2'd0, C_FLAG);
                rd_chk("R11 clear", 2'd0, 8'h00);
            end
        end

        // R10 interrupt gating sweep
        for (int v = 0; v < 8; v++) begin
            int f, ie, g;
            f = v & 1; ie = (v >> 1) & 1; g = (v >> 2) & 1;
            if (f != 0) load_code(5'd1);
            wr(2'd0, (ie != 0 ? C_IE : 8'h00) | (f != 0 ? 8'h00 : C_FLAG));
            global_irq_en = (g != 0);
            #0.2;
            chk("R10 irq", irq, f & ie & g);
        end

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end
endmodule